// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block moves bytes over a two-wire synchronous link: one output carries a shift clock it generates itself, and one shared data line carries bits in either direction, one direction at a time. The data line is modelled as three pins: an output value, an output enable and an input value, which a pad cell combines. Bits travel least significant first. The shift clock idles high, and each bit is taken on a rising edge. This matches the clock-polarity-1, clock-phase-1 mode of common SPI peripherals, with bit order left to software.

Software starts a transmit by writing a byte with a one-cycle write strobe. It starts a receive by holding the receive enable high while the receive-done flag is clear. The bit period is 4 or 12 system clocks, chosen by a rate select input. The port samples that select when a transfer starts. Each direction has a done flag, which stays set until software clears it. A busy output is high for the whole of a transfer.

Top module: `ssp_port`

## Requirements
- R1: After reset, sclk_o is 1, sd_oe_o is 0, busy_o is 0, tx_done_o and rx_done_o are 0, and rx_byte_o is 0.
- R2: In a transmit, sd_oe_o is 1 and bit k of the written byte (k = 0 first, up to 7) appears on sd_o for the whole of the k-th bit period.
- R3: sclk_o is 1 whenever the port is idle. Within each bit period it is 0 for the first half and 1 for the second half, so it rises mid-bit.
- R4: A bit period is 4 system clocks when fast_sel_i is 1 and 12 when it is 0. The value is taken when the transfer starts, and changing it during the transfer has no effect.
- R5: In a receive, sd_oe_o is 0 and sd_i is sampled at the clock edge on which sclk_o rises. The first sample is bit 0 of the byte. When the transfer ends, the assembled byte appears on rx_byte_o.
- R6: busy_o rises in the cycle after the start and stays high for exactly 8 bit periods.
- R7: tx_done_o is set on the edge that ends a transmit and holds until tx_clr_i is 1. A completion in the same cycle as a clear leaves the flag set.
- R8: A receive starts only when the port is idle, rx_en_i is 1 and rx_done_o is 0. rx_done_o is set on the edge that ends a receive and holds until rx_clr_i is 1.
- R9: A tx_wr_i pulse while busy_o is 1 is ignored: the byte being sent and its timing do not change.
- R10: If tx_wr_i and a receive start condition occur in the same idle cycle, the transmit starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_sel_i | input | 1 | 1: bit period of 4 clocks, 0: bit period of 12 clocks |
| tx_wr_i | input | 1 | One-cycle strobe that writes tx_data_i and starts a transmit |
| tx_data_i | input | 8 | Byte to transmit |
| tx_clr_i | input | 1 | Clears the transmit-done flag |
| rx_en_i | input | 1 | Receive enable |
| rx_clr_i | input | 1 | Clears the receive-done flag |
| sd_i | input | 1 | Value read from the shared data line |
| sd_o | output | 1 | Value driven onto the shared data line |
| sd_oe_o | output | 1 | Drive enable for the shared data line |
| sclk_o | output | 1 | Shift clock, idles high |
| rx_byte_o | output | 8 | Last received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions assume that rst_n is held low from time zero until the first clock edges have passed. They also assume that sd_i is stable around the rising edge of sclk_o, since the design samples it once without any voting. The stimulus changes sd_i only in the cycle after sclk_o has been seen to fall. It changes every control input at the falling system-clock edge. A behavioural model is compared against every output on every cycle. The stimulus includes writes and rate changes issued during transfers, a done clear held over a completion, and a transmit request that collides with a receive start.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fast_i,
    input  logic run_i,
    input  logic last_bit_i,
    output logic sclk_o,
    output logic rise_o,
    output logic bit_end_o
);
    localparam int PHW = $clog2(DIV_SLOW);

    typedef struct packed {
        logic [PHW-1:0] ph;
        logic           fast;
        logic           sclk;
    } clk_state_t;

    clk_state_t st_d, st_q;
    logic [PHW-1:0] per_last, half_pt, rise_pt;

    always_comb begin
        per_last = st_q.fast ? PHW'(DIV_FAST - 1) : PHW'(DIV_SLOW - 1);
        half_pt  = st_q.fast ? PHW'(DIV_FAST / 2) : PHW'(DIV_SLOW / 2);
        rise_pt  = st_q.fast ? PHW'(DIV_FAST / 2 - 1) : PHW'(DIV_SLOW / 2 - 1);
    end

    assign rise_o    = run_i && (st_q.ph == rise_pt);
    assign bit_end_o = run_i && (st_q.ph == per_last);
    assign sclk_o    = st_q.sclk;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.ph   = '0;
            st_d.fast = fast_i;
            st_d.sclk = 1'b0;
        end else if (run_i) begin
            if (bit_end_o) begin
                st_d.ph   = '0;
                st_d.sclk = last_bit_i;
            end else begin
                st_d.ph   = st_q.ph + 1'b1;
                st_d.sclk = (st_d.ph >= half_pt);
            end
        end else begin
            st_d.sclk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= '0;
            st_q.fast <= 1'b0;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= per_last);
    assert_rise_mid_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sclk) |-> (st_q.ph == half_pt));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          sample_i,
    input  logic          sin_i,
    input  logic          shift_i,
    output logic [DW-1:0] sreg_o
);
    logic [DW-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (load_i)
            sreg_d = load_val_i;
        else if (sample_i)
            sreg_d = {sin_i, sreg_q[DW-1:1]};
        else if (shift_i)
            sreg_d = {1'b0, sreg_q[DW-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;

    assert_load_takes_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sreg_q == $past(load_val_i)));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast_sel_i,
    input  logic          tx_wr_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          tx_clr_i,
    input  logic          rx_en_i,
    input  logic          rx_clr_i,
    input  logic          sd_i,
    output logic          sd_o,
    output logic          sd_oe_o,
    output logic          sclk_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          tx_done_o,
    output logic          rx_done_o,
    output logic          busy_o
);
    localparam int BCW = $clog2(DW);

    typedef struct packed {
        xfer_mode_e     mode;
        logic [BCW-1:0] bitcnt;
        logic           txdone;
        logic           rxdone;
        logic [DW-1:0]  rxbyte;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic tx_start, rx_start, start, last_bit, fin;
    logic rise, bit_end;
    logic [DW-1:0] sreg;

    assign last_bit = (ctl_q.bitcnt == BCW'(DW - 1));
    assign fin      = bit_end && last_bit;

    ssp_clkgen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) clkgen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .fast_i     (fast_sel_i),
        .run_i      (ctl_q.mode != MODE_IDLE),
        .last_bit_i (last_bit),
        .sclk_o     (sclk_o),
        .rise_o     (rise),
        .bit_end_o  (bit_end)
    );

    ssp_shifter #(.DW(DW)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_val_i (tx_start ? tx_data_i : '0),
        .sample_i   (rise && (ctl_q.mode == MODE_RX)),
        .sin_i      (sd_i),
        .shift_i    (bit_end && (ctl_q.mode == MODE_TX)),
        .sreg_o     (sreg)
    );

    always_comb begin
        tx_start = tx_wr_i && (ctl_q.mode == MODE_IDLE);
        rx_start = !tx_wr_i && (ctl_q.mode == MODE_IDLE) && rx_en_i && !ctl_q.rxdone;
        start    = tx_start || rx_start;

        ctl_d = ctl_q;
        if (tx_start) begin
            ctl_d.mode   = MODE_TX;
            ctl_d.bitcnt = '0;
        end else if (rx_start) begin
            ctl_d.mode   = MODE_RX;
            ctl_d.bitcnt = '0;
        end else if (fin) begin
            ctl_d.mode = MODE_IDLE;
        end else if (bit_end) begin
            ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
        end

        if (fin && ctl_q.mode == MODE_TX) ctl_d.txdone = 1'b1;
        else if (tx_clr_i)                ctl_d.txdone = 1'b0;

        if (fin && ctl_q.mode == MODE_RX) begin
            ctl_d.rxdone = 1'b1;
            ctl_d.rxbyte = sreg;
        end else if (rx_clr_i) begin
            ctl_d.rxdone = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode   <= MODE_IDLE;
            ctl_q.bitcnt <= '0;
            ctl_q.txdone <= 1'b0;
            ctl_q.rxdone <= 1'b0;
            ctl_q.rxbyte <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sd_o      = sreg[0];
    assign sd_oe_o   = (ctl_q.mode == MODE_TX);
    assign busy_o    = (ctl_q.mode != MODE_IDLE);
    assign rx_byte_o = ctl_q.rxbyte;
    assign tx_done_o = ctl_q.txdone;
    assign rx_done_o = ctl_q.rxdone;

    assert_idle_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o);
    assert_tx_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_o) |-> $fell(busy_o));
    assert_rx_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_RX && $past(ctl_q.mode) == MODE_IDLE)
        |-> ($past(rx_en_i) && !$past(ctl_q.rxdone) && !$past(tx_wr_i)));
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tx_wr_i && !fin) |=> $stable(sd_oe_o) && busy_o);
    assert_rx_line_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_RX) |-> !sd_oe_o);
endmodule

// File: tb/ssp_port_tb_top.sv
module ssp_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_sel = 1'b1, tx_wr = 1'b0, tx_clr = 1'b0, rx_en = 1'b0, rx_clr = 1'b0, sd_in = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic sd_out, sd_oe, sclk, tx_done, rx_done, busy;
    logic [7:0] rx_byte;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_port dut_i (
        .clk(clk), .rst_n(rst_n), .fast_sel_i(fast_sel), .tx_wr_i(tx_wr),
        .tx_data_i(tx_data), .tx_clr_i(tx_clr), .rx_en_i(rx_en), .rx_clr_i(rx_clr),
        .sd_i(sd_in), .sd_o(sd_out), .sd_oe_o(sd_oe), .sclk_o(sclk),
        .rx_byte_o(rx_byte), .tx_done_o(tx_done), .rx_done_o(rx_done), .busy_o(busy)
    );

    // behavioural reference: 0 idle, 1 transmit, 2 receive
    int m_mode = 0, m_ph = 0, m_bit = 0;
    bit m_fast = 1'b0, m_txd = 1'b0, m_rxd = 1'b0;
    logic [7:0] m_sreg = 8'h00, m_rxb = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ph = 0; m_bit = 0; m_txd = 0; m_rxd = 0; m_sreg = 0; m_rxb = 0;
        end else begin
            int per;
            bit set_tx, set_rx;
            per = m_fast ? 4 : 12;
            set_tx = 0; set_rx = 0;
            if (m_mode == 0) begin
                if (tx_wr) begin
                    m_mode = 1; m_ph = 0; m_bit = 0; m_sreg = tx_data; m_fast = fast_sel;
                end else if (rx_en && !m_rxd) begin
                    m_mode = 2; m_ph = 0; m_bit = 0; m_sreg = 0; m_fast = fast_sel;
                end
            end else begin
                if (m_mode == 2 && m_ph == per/2 - 1) m_sreg = {sd_in, m_sreg[7:1]};
                if (m_ph == per - 1) begin
                    if (m_mode == 1) m_sreg = m_sreg >> 1;
                    m_ph = 0;
                    if (m_bit == 7) begin
                        if (m_mode == 1) set_tx = 1;
                        else begin set_rx = 1; m_rxb = m_sreg; end
                        m_mode = 0;
                    end else m_bit++;
                end else m_ph++;
            end
            m_txd = set_tx ? 1'b1 : (tx_clr ? 1'b0 : m_txd);
            m_rxd = set_rx ? 1'b1 : (rx_clr ? 1'b0 : m_rxd);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            int half;
            half = m_fast ? 2 : 6;
            check(sclk === ((m_mode == 0) ? 1'b1 : (m_ph >= half)), "R3 sclk", sclk, (m_mode == 0) ? 1 : (m_ph >= half));
            check(sd_oe === (m_mode == 1), "R2 sd_oe", sd_oe, m_mode == 1);
            if (m_mode == 1) check(sd_out === m_sreg[0], "R2 sd_o", sd_out, m_sreg[0]);
            check(busy === (m_mode != 0), "R6 busy", busy, m_mode != 0);
            check(tx_done === m_txd, "R7 tx_done", tx_done, m_txd);
            check(rx_done === m_rxd, "R8 rx_done", rx_done, m_rxd);
            check(rx_byte === m_rxb, "R5 rx_byte", rx_byte, m_rxb);
        end
    end

    // transmit one byte; count busy cycles; optional mid-transfer disturbance (R9, R4)
    task automatic send(input logic [7:0] b, input bit fast, input bit disturb);
        int n;
        @(negedge clk); tx_data = b; fast_sel = fast; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            if (disturb && n == 5) begin tx_data = ~b; tx_wr = 1'b1; fast_sel = ~fast; end
            else tx_wr = 1'b0;
            @(negedge clk);
        end
        tx_wr = 1'b0;
        check(n == 8 * (fast ? 4 : 12), "R6 R4 R9 busy length", n, 8 * (fast ? 4 : 12));
        check(tx_done === 1'b1, "R7 done after transmit", tx_done, 1);
    endtask

    // receive one byte; sd_i changes right after each observed falling sclk
    task automatic recv(input logic [7:0] pat, input bit fast);
        int idx, guard;
        bit prev;
        @(negedge clk); fast_sel = fast; rx_en = 1'b1;
        idx = 0; prev = sclk; guard = 0;
        @(negedge clk);
        check(busy === 1'b1, "R8 receive started", busy, 1);
        while (busy && guard < 200) begin
            if (prev && !sclk && idx < 8) begin sd_in = pat[idx]; idx++; end
            prev = sclk; guard++;
            @(negedge clk);
            if (busy && !sclk && prev && idx < 8) begin sd_in = pat[idx]; idx++; prev = 1'b0; end
        end
        check(rx_byte === pat, "R5 received byte", rx_byte, pat);
        check(rx_done === 1'b1, "R8 rx_done set", rx_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk === 1'b1 && sd_oe === 1'b0 && busy === 1'b0, "R1 reset pins", {sclk, sd_oe, busy}, 3'b100);
        check(tx_done === 1'b0 && rx_done === 1'b0 && rx_byte === 8'h00, "R1 reset flags",
              {tx_done, rx_done, rx_byte}, 0);
        rst_n = 1'b1; cmp_en = 1'b1;
        repeat (2) @(negedge clk);

        send(8'hA5, 1'b1, 1'b0);
        tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
        check(tx_done === 1'b0, "R7 clear", tx_done, 0);
        send(8'h3C, 1'b0, 1'b0);
        tx_clr = 1'b1;
        send(8'h81, 1'b1, 1'b0);   // clear held through completion: set wins (R7)
        tx_clr = 1'b0;
        send(8'hC3, 1'b1, 1'b1);   // write and rate change while busy (R9, R4)
        send(8'h5E, 1'b0, 1'b1);

        recv(8'h96, 1'b1);
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R8 no receive while rx_done set", busy, 0);
        rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
        rx_en = 1'b0;
        @(negedge clk);
        recv(8'h5A, 1'b0);
        rx_en = 1'b0;
        rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
        recv(8'h01, 1'b1);
        rx_en = 1'b0;
        rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;

        // transmit request collides with a receive start (R10)
        rx_en = 1'b1; tx_data = 8'h7E; fast_sel = 1'b1; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        check(sd_oe === 1'b1, "R10 transmit wins", sd_oe, 1);
        rx_en = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule